// File: doc/BRIEF.md
# Four-Point Cosine Transform by Distributed Arithmetic

This block computes a four-point one-dimensional cosine transform with no multipliers. Four signed samples enter one per accepted cycle and are gathered in a word-wide serial-in shift register. The gathered words are then copied into a bit-serial register. That register presents, on each cycle, the same bit position of all four samples, starting from the least significant bit. The four-bit slice addresses four small constant tables, one per output coefficient. Each table holds every partial sum of that output's quantised cosine weights. Each table feeds its own shift-accumulator, which subtracts instead of adding on the sign-bit cycle.

When the four bit cycles are done, the four results are copied into a word-wide output shift register and leave on four consecutive cycles, Y(0) first. One ten-state controller runs the sequence. While the results drain, the block is already accepting the next block of samples.

Top module: `dadct_top`

## Requirements
- R1: While reset is asserted and right after it, in_ready is 1, out_valid is 0 and out_data is 0.
- R2: A sample is taken only on a cycle with in_valid and in_ready both high. The first sample taken in a block is y(0) and the fourth is y(3). Samples are 4-bit two's complement.
- R3: After the cycle that takes y(3), in_ready stays low for exactly 6 cycles and then returns high.
- R4: out_valid rises on the same clock edge as in_ready returns. That is the 6th rising edge after the edge that took y(3).
- R5: Each block gives exactly four valid cycles in a row, carrying Y(0), Y(1), Y(2), Y(3) in that order. out_valid then falls.
- R6: Y(k) equals the sum over n of y(n)·q((n·k) mod 16), where q(m) = round(64·cos(π·m/8)). The values of q(0..15) are 64, 59, 45, 24, 0, −24, −45, −59, −64, −59, −45, −24, 0, 24, 45, 59. Y(k) is exact and is given as a 12-bit two's complement word.
- R7: The most negative input, y(n) = −8 for all n, is weighted negatively on its sign bit, so Y(0) = −2048 exactly.
- R8: in_ready is high on every cycle on which out_valid is high. A block fed during the draining of the previous block gives correct results.
- R9: out_data is 0 on every cycle on which out_valid is low.
- R10: When in_valid is high while in_ready is low, nothing is taken, and the results of the block in progress do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is offered on in_data |
| in_ready | output | 1 | The block can take a sample this cycle |
| in_data | input | 4 | Signed input sample |
| out_valid | output | 1 | out_data carries a coefficient |
| out_data | output | 12 | Signed transform coefficient, scaled by 64 |

## Verification
The assertions check the following on every cycle:
- the timing at the handshake edges: the busy window lasts exactly six cycles, out_valid rises together with in_ready, and draining never happens while input is blocked;
- the four-cycle output burst;
- the zero value on out_data when it is idle.

The numerical result cannot be checked cycle by cycle. Only the bench's scenarios show it, by comparing each coefficient with an independent weighted sum. These scenarios cover the most negative and the most positive operands, impulses, random blocks, and a block fed during the drain. The bench also shows that samples offered while busy are ignored, because the results of the block in progress stay correct.

// File: rtl/dadct_pkg.sv
package dadct_pkg;
  localparam int PTS       = 4;              // transform length
  localparam int DATA_W    = PTS;            // sample width equals bit-cycle count
  localparam int COEF_FRAC = 6;              // fractional bits of a weight
  localparam int ROM_W     = 10;             // partial-sum word width
  localparam int ROM_DEPTH = 1 << PTS;
  localparam int ACC_W     = ROM_W + DATA_W;
  localparam int OUT_W     = 12;
  localparam int PHASES    = 4 * PTS;        // cosine period in index steps
  localparam int CNT_W     = $clog2(PTS + 1);

  typedef struct packed {
    logic sipoShift;   // take a sample into the input register
    logic pisoLoad;    // copy samples to the bit-serial register, clear sums
    logic accStep;     // one distributed-arithmetic bit cycle
    logic signCycle;   // current bit is the sign bit
    logic outLoad;     // copy sums into the output register
  } ctrlStrobes_t;

  // quantised cosine weight for phase index m, built from one quarter wave
  function automatic int coefQ(input int m);
    int r;
    int qtr[5];
    qtr = '{64, 59, 45, 24, 0};
    r = m % PHASES;
    if (r <= PTS)            return qtr[r];
    else if (r <= 2 * PTS)   return -qtr[2 * PTS - r];
    else if (r <= 3 * PTS)   return -qtr[r - 2 * PTS];
    else                     return qtr[PHASES - r];
  endfunction

  // partial sum of output k's weights selected by the bits of addr
  function automatic int romEntry(input int k, input int addr);
    int s;
    s = 0;
    for (int n = 0; n < PTS; n++)
      if (((addr >> n) & 1) == 1) s += coefQ(n * k);
    return s;
  endfunction
endpackage

// File: rtl/dadct_ctrl.sv
module dadct_ctrl
  import dadct_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output logic         inReady,
  output ctrlStrobes_t strobes
);
  typedef enum logic [3:0] {
    S0, S1, S2, S3,          // take y(0)..y(3)
    S4,                      // load bit-serial register
    S5, S6, S7, S8,          // bit cycles, S8 is the sign bit
    S9                       // load output register
  } state_t;

  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S0: if (inValid) stateNext = S1;
      S1: if (inValid) stateNext = S2;
      S2: if (inValid) stateNext = S3;
      S3: if (inValid) stateNext = S4;
      S4: stateNext = S5;
      S5: stateNext = S6;
      S6: stateNext = S7;
      S7: stateNext = S8;
      S8: stateNext = S9;
      S9: stateNext = S0;
      default: stateNext = S0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S0;
    else        state <= stateNext;
  end

  always_comb begin
    inReady           = (state <= S3);
    strobes.sipoShift = inReady && inValid;
    strobes.pisoLoad  = (state == S4);
    strobes.accStep   = (state >= S5) && (state <= S8);
    strobes.signCycle = (state == S8);
    strobes.outLoad   = (state == S9);
  end
endmodule

// File: rtl/dadct_accum.sv
module dadct_accum
  import dadct_pkg::*;
#(
  parameter int K = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic                    signCycle,
  input  logic [PTS-1:0]          slice,
  output logic signed [OUT_W-1:0] result
);
  logic signed [ROM_W-1:0] rom [ROM_DEPTH];
  logic signed [ROM_W-1:0] romWord;
  logic signed [ACC_W-1:0] acc, shifted, addend;

  always_comb begin
    for (int a = 0; a < ROM_DEPTH; a++) rom[a] = ROM_W'(romEntry(K, a));
    romWord = rom[slice];
    shifted = acc >>> 1;
    addend  = {{DATA_W{romWord[ROM_W-1]}}, romWord} <<< (DATA_W - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc <= '0;
    else if (step)       acc <= signCycle ? shifted - addend : shifted + addend;
  end

  assign result = acc[OUT_W-1:0];
endmodule

// File: rtl/dadct_datapath.sv
module dadct_datapath
  import dadct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData
);
  logic [DATA_W-1:0] sipo [PTS];
  logic [DATA_W-1:0] piso [PTS];
  logic [PTS-1:0]    slice;
  logic [PTS-1:0][OUT_W-1:0] sums;
  logic [OUT_W-1:0]  outBuf [PTS];
  logic [CNT_W-1:0]  outLeft;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PTS; i++) sipo[i] <= '0;
    end else if (strobes.sipoShift) begin
      for (int i = 0; i < PTS - 1; i++) sipo[i] <= sipo[i+1];
      sipo[PTS-1] <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PTS; i++) piso[i] <= '0;
    end else if (strobes.pisoLoad) begin
      for (int i = 0; i < PTS; i++) piso[i] <= sipo[i];
    end else if (strobes.accStep) begin
      for (int i = 0; i < PTS; i++) piso[i] <= piso[i] >> 1;
    end
  end

  always_comb
    for (int i = 0; i < PTS; i++) slice[i] = piso[i][0];

  for (genvar k = 0; k < PTS; k++) begin : g_acc
    dadct_accum #(.K(k)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (strobes.pisoLoad),
      .step     (strobes.accStep),
      .signCycle(strobes.signCycle),
      .slice    (slice),
      .result   (sums[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outLeft <= '0;
      for (int i = 0; i < PTS; i++) outBuf[i] <= '0;
    end else if (strobes.outLoad) begin
      outLeft <= CNT_W'(PTS);
      for (int i = 0; i < PTS; i++) outBuf[i] <= sums[i];
    end else if (outLeft != 0) begin
      outLeft <= outLeft - 1'b1;
      for (int i = 0; i < PTS - 1; i++) outBuf[i] <= outBuf[i+1];
      outBuf[PTS-1] <= '0;
    end
  end

  assign outValid = (outLeft != 0);
  assign outData  = outValid ? outBuf[0] : '0;
endmodule

// File: rtl/dadct_top.sv
module dadct_top
  import dadct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  ctrlStrobes_t strobes;

  dadct_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .inValid(in_valid),
    .inReady(in_ready),
    .strobes(strobes)
  );

  dadct_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .inData  (in_data),
    .outValid(out_valid),
    .outData (out_data)
  );
endmodule

// File: rtl/dadct_checker.sv
module dadct_checker
  import dadct_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  logic [3:0] validRun, busyRun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validRun <= '0;
      busyRun  <= '0;
    end else begin
      validRun <= out_valid ? ((validRun == 4'hF) ? validRun : validRun + 1'b1) : '0;
      busyRun  <= !in_ready ? ((busyRun == 4'hF) ? busyRun : busyRun + 1'b1) : '0;
    end
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> busyRun == 4'd6);

  p_valid_with_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $rose(in_ready));

  p_burst_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> validRun < 4'd4);

  p_burst_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> validRun == 4'd4);

  p_drain_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);
endmodule

bind dadct_top dadct_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/tb_dadct_top.sv
module tb_dadct_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_data = '0;
  logic        out_valid;
  logic [11:0] out_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  dadct_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int wq(input int m);
    case (m % 16)
      0: return 64;   1: return 59;   2: return 45;   3: return 24;
      4: return 0;    5: return -24;  6: return -45;  7: return -59;
      8: return -64;  9: return -59;  10: return -45; 11: return -24;
      12: return 0;   13: return 24;  14: return 45;  default: return 59;
    endcase
  endfunction

  function automatic int refY(input int y[4], input int k);
    int s = 0;
    for (int n = 0; n < 4; n++) s += y[n] * wq(n * k);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1 && out_valid == 0, "R1 handshake during reset", {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(in_ready == 1 && out_valid == 0, "R1 handshake after reset", {in_ready, out_valid}, 2);
    check(out_data == 0, "R1 data after reset", int'(out_data), 0);
  endtask

  task automatic sendBlock(input int y[4]);
    for (int i = 0; i < 4; i++) begin
      check(in_ready == 1, "R2 ready for sample", in_ready, 1);
      in_valid = 1'b1; in_data = 4'(y[i]);
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // wait for results, optionally pushing junk while busy or the next block while draining
  task automatic collect(input int y[4], input bit junk, input bit feedNext, input int nxt[4]);
    int waits = 0;
    while (!out_valid && waits < 20) begin
      check(in_ready == 0, "R3 busy window", in_ready, 0);
      check(out_data == 0, "R9 idle data", int'(out_data), 0);
      in_valid = junk; in_data = 4'($urandom);   // R10 ignored while busy
      @(posedge clk); @(negedge clk);
      waits++;
    end
    in_valid = 1'b0;
    check(waits == 6, "R4 latency to first result", waits, 6);
    check(in_ready == 1, "R3 ready returns with results", in_ready, 1);
    for (int k = 0; k < 4; k++) begin
      check(out_valid == 1, "R5 burst valid", out_valid, 1);
      check($signed(out_data) == refY(y, k), "R6 coefficient", $signed(out_data), refY(y, k));
      check(in_ready == 1, "R8 ready while draining", in_ready, 1);
      if (feedNext) begin in_valid = 1'b1; in_data = 4'(nxt[k]); end
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
    check(out_valid == 0, "R5 burst ends after four", out_valid, 0);
    check(out_data == 0, "R9 data zero after burst", int'(out_data), 0);
  endtask

  task automatic runOne(input int y[4], input bit junk);
    int none[4] = '{0, 0, 0, 0};
    sendBlock(y);
    collect(y, junk, 1'b0, none);
  endtask

  task automatic test_zero();
    runOne('{0, 0, 0, 0}, 1'b0);
  endtask

  task automatic test_max_negative();
    int y[4] = '{-8, -8, -8, -8};
    int none[4] = '{0, 0, 0, 0};
    sendBlock(y);
    collect(y, 1'b0, 1'b0, none);
    check(refY(y, 0) == -2048, "R7 reference of most negative block", refY(y, 0), -2048);
  endtask

  task automatic test_max_positive();
    runOne('{7, 7, 7, 7}, 1'b0);
  endtask

  task automatic test_impulses();
    runOne('{1, 0, 0, 0}, 1'b0);
    runOne('{0, 0, 0, -8}, 1'b0);
    runOne('{7, -8, 7, -8}, 1'b0);
  endtask

  task automatic test_busy_ignored();
    runOne('{3, -5, 6, -1}, 1'b1);   // R10
  endtask

  task automatic test_overlap();
    int a[4] = '{5, -3, 2, -7};
    int b[4] = '{-6, 4, -1, 7};
    int none[4] = '{0, 0, 0, 0};
    sendBlock(a);
    collect(a, 1'b0, 1'b1, b);       // R8: b fed while a drains
    collect(b, 1'b0, 1'b0, none);
  endtask

  task automatic test_random();
    for (int t = 0; t < 10; t++) begin
      int y[4];
      for (int n = 0; n < 4; n++) y[n] = int'($urandom_range(15)) - 8;
      runOne(y, t[0]);
    end
  endtask

  initial begin
    doReset();
    test_zero();
    test_max_negative();
    test_max_positive();
    test_impulses();
    test_busy_ignored();
    test_overlap();
    test_random();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule